// File: doc/BRIEF.md
# Dual-Timer Pixel Trigger Coincidence Array

This block is the digital back end of a small pixel matrix, arranged as `NCOLS` columns of `NROWS` pixels. Each discriminated hit starts one of two delay timers in its pixel. The timer counts a programmable latency that matches the decision time of the external trigger. When the count ends, the timer looks at the trigger strobe in that one cycle. A hit that lines up with an asserted strobe becomes a record. A hit that misses the strobe is dropped, so hits from background never reach the readout.

Accepted records wait in the timer until the column arbiter picks them. Within a column the lowest row wins, and timer 0 goes before timer 1. The record is written into a small column FIFO. A chip-level stage then takes one record per cycle from the lowest-numbered non-empty column and writes it into a global FIFO, which drives the output stream. A 12-bit trigger counter lives inside the block. Each record is stamped with the number of the strobe it matched.

Each timer is a four-state machine:
- `T_IDLE` goes to `T_COUNT` on a hit when the latency is not zero, and to `T_DECIDE` when the latency is zero.
- `T_COUNT` goes to `T_DECIDE` when its counter reaches one.
- `T_DECIDE` goes to `T_HOLD` if the trigger strobe is high, and back to `T_IDLE` if it is low.
- `T_HOLD` goes to `T_IDLE` when the arbiter grants the record, or when the column FIFO is full and the record is dropped.

Top module: `hc_coinc_top`

## Requirements
- R1: After reset, `out_valid` is 0, all overflow counters are 0, all lost counters are 0, and the first trigger strobe is numbered 0.
- R2: A hit sampled in cycle t with latency L is tested against `trig_in` in cycle t+1+L only. A strobe in that cycle gives exactly one output word. A strobe one cycle earlier or one cycle later gives none. L=0 tests in cycle t+1.
- R3: The latency is captured when the hit starts a timer. A later change of `lat_cfg` does not move the test cycle of a timer that is already running.
- R4: A hit that arrives while timer 0 of the same pixel is busy starts timer 1. Both hits can be read out.
- R5: A hit that arrives while both timers of its pixel are busy is discarded. It increments that pixel's overflow counter, which saturates at 2^OVF_W-1 and sits at bits [p*OVF_W +: OVF_W] of `ovf_cnt` for pixel p = col*NROWS+row.
- R6: The trigger counter is 12 bits wide. It increments on every cycle with `trig_in` high and wraps from 4095 to 0. A word carries the counter value from before the increment of the strobe it matched.
- R7: The output word is {trigger id[11:0], column, row}, with the row in the low ROW_W bits (2 by default) and the column in the next COL_W bits (1 by default).
- R8: Records accepted in the same cycle leave in ascending row order within a column. Columns are served lowest index first.
- R9: If a column FIFO is full, every record that is waiting in that column is dropped and added to that column's lost counter at `lost_cnt[c*LOST_W +: LOST_W]`. The timers are released and are not stalled.
- R10: While `out_valid` is high and `out_ready` is low, `out_word` holds its value and no word is lost.
- R11: A hit without a coincident strobe produces no word and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_in | input | NCOLS*NROWS | Hit event per pixel and cycle, bit col*NROWS+row |
| trig_in | input | 1 | Global trigger strobe |
| lat_cfg | input | 8 | Trigger latency in clock cycles |
| out_ready | input | 1 | Consumer takes the output word |
| out_valid | output | 1 | Output word present |
| out_word | output | 12+COL_W+ROW_W | Tagged hit word {tid, col, row} |
| ovf_cnt | output | NCOLS*NROWS*OVF_W | Per-pixel overflow counters |
| lost_cnt | output | NCOLS*LOST_W | Per-column lost-record counters |

## Verification
The hardest case to reach from the ports is a full column FIFO while records are waiting in `T_HOLD`. The global FIFO normally drains the column at the same rate as the column fills it. The stimulus therefore holds `out_ready` low and fires rounds of simultaneous hits on all four rows of one column, each round followed by a zero-latency strobe. After the global FIFO and then the column FIFO fill up, the fourth round is dropped as a whole. The lost count, the held output word and the number of words drained afterwards are then checked. A latency sweep over every pixel, with the strobe placed one cycle early, on time and one cycle late, covers the coincidence window.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int TID_W = 12;
    localparam int LAT_W = 8;

    typedef enum logic [1:0] {
        T_IDLE   = 2'd0,
        T_COUNT  = 2'd1,
        T_DECIDE = 2'd2,
        T_HOLD   = 2'd3
    } tmr_state_t;
endpackage

// File: rtl/hc_fifo.sv
module hc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign dout  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
            if (pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // R9: the column logic must never write a full FIFO
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10: the output side must never read an empty FIFO
    a_r10_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/hc_timer.sv
module hc_timer
    import hc_pkg::*;
#(
    parameter int LW = 8,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] lat_in,
    input  logic          trig,
    input  logic [TW-1:0] tid_in,
    input  logic          grant,
    input  logic          drop,
    output logic          busy,
    output logic          req,
    output logic [TW-1:0] tid_out
);
    tmr_state_t    state_q, state_d;
    logic [LW-1:0] cnt_q;
    logic [TW-1:0] tid_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:   if (start) state_d = (lat_in == '0) ? T_DECIDE : T_COUNT;
            T_COUNT:  if (cnt_q == LW'(1)) state_d = T_DECIDE;
            T_DECIDE: state_d = trig ? T_HOLD : T_IDLE;
            T_HOLD:   if (grant || drop) state_d = T_IDLE;
            default:  state_d = T_IDLE;
        endcase
    end

    // latency counter and captured trigger number
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tid_q <= '0;
        end else begin
            if (state_q == T_IDLE && start) cnt_q <= lat_in;
            else if (state_q == T_COUNT)    cnt_q <= cnt_q - LW'(1);
            if (state_q == T_DECIDE && trig) tid_q <= tid_in;
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != T_IDLE);
        req     = (state_q == T_HOLD);
        tid_out = tid_q;
    end

    // R2: a zero latency tests the strobe in the very next cycle
    a_r2_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_IDLE && start && lat_in == '0) |=> state_q == T_DECIDE);
    // R2: the last count step leads into the decision cycle
    a_r2_count_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_COUNT && cnt_q == LW'(1)) |=> state_q == T_DECIDE);
    // R3: a running count moves by one per cycle, whatever lat_in does
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_COUNT && $past(state_q) == T_COUNT) |-> cnt_q == $past(cnt_q) - LW'(1));
    // R9: a dropped record frees the timer at once
    a_r9_drop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_HOLD && drop) |=> state_q == T_IDLE);
endmodule

// File: rtl/hc_column.sv
module hc_column #(
    parameter int NROWS  = 4,
    parameter int DEPTH  = 4,
    parameter int OVF_W  = 4,
    parameter int LOST_W = 8,
    parameter int TW     = 12,
    parameter int LW     = 8,
    localparam int ROW_W = (NROWS > 1) ? $clog2(NROWS) : 1,
    localparam int REC_W = TW + ROW_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NROWS-1:0]       hit,
    input  logic                   trig,
    input  logic [TW-1:0]          tid,
    input  logic [LW-1:0]          lat,
    input  logic                   pop,
    output logic                   rec_valid,
    output logic [REC_W-1:0]       rec,
    output logic [NROWS*OVF_W-1:0] ovf,
    output logic [LOST_W-1:0]      lost
);
    localparam int NREQ  = 2 * NROWS;
    localparam int IDX_W = $clog2(NREQ);
    localparam int SUM_W = LOST_W + IDX_W + 1;

    logic [NREQ-1:0]  busy, req, start, grant;
    logic [TW-1:0]    ttid [NREQ];
    logic             fifo_full, fifo_empty, push, found;
    logic [IDX_W-1:0] sel;
    logic [IDX_W:0]   nhold;
    logic [REC_W-1:0] rec_din;
    logic [SUM_W-1:0] lost_sum;
    logic [LOST_W-1:0] lost_q;

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        logic             ovf_ev;
        logic [OVF_W-1:0] ovf_q;

        assign start[2*r]   = hit[r] & ~busy[2*r];
        assign start[2*r+1] = hit[r] &  busy[2*r] & ~busy[2*r+1];
        assign ovf_ev       = hit[r] &  busy[2*r] &  busy[2*r+1];

        for (genvar t = 0; t < 2; t++) begin : g_tmr
            hc_timer #(.LW(LW), .TW(TW)) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .start   (start[2*r+t]),
                .lat_in  (lat),
                .trig    (trig),
                .tid_in  (tid),
                .grant   (grant[2*r+t]),
                .drop    (fifo_full),
                .busy    (busy[2*r+t]),
                .req     (req[2*r+t]),
                .tid_out (ttid[2*r+t])
            );
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       ovf_q <= '0;
            else if (ovf_ev && ovf_q != '1)   ovf_q <= ovf_q + OVF_W'(1);
        end
        assign ovf[r*OVF_W +: OVF_W] = ovf_q;

        // R5: a hit with both timers busy bumps the pixel's overflow count
        a_r5_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_ev && ovf_q != '1) |=> ovf_q == $past(ovf_q) + OVF_W'(1));
        // R4: a second hit is taken by timer 1 while timer 0 is busy
        a_r4_second_timer: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[r] && busy[2*r] && !busy[2*r+1]) |=> busy[2*r+1]);
    end

    // fixed-priority pick: lowest row first, timer 0 before timer 1
    always_comb begin
        sel   = '0;
        found = 1'b0;
        nhold = '0;
        for (int i = 0; i < NREQ; i++) begin
            nhold = nhold + (IDX_W+1)'(req[i]);
            if (req[i] && !found) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign push    = found & ~fifo_full;
    assign grant   = push ? (NREQ'(1) << sel) : '0;
    assign rec_din = {ttid[sel], ROW_W'(sel >> 1)};

    hc_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_cfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rec_din),
        .pop   (pop),
        .dout  (rec),
        .empty (fifo_empty),
        .full  (fifo_full)
    );
    assign rec_valid = ~fifo_empty;

    assign lost_sum = SUM_W'(lost_q) + SUM_W'(nhold);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lost_q <= '0;
        else if (fifo_full && nhold != '0)
            lost_q <= (lost_sum > SUM_W'({LOST_W{1'b1}})) ? '1 : LOST_W'(lost_sum);
    end
    assign lost = lost_q;

    // R8: at most one record enters the column FIFO per cycle
    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R9: waiting records facing a full FIFO always show up as losses
    a_r9_lost_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && |req) |=> lost_q != '0);
endmodule

// File: rtl/hc_coinc_top.sv
module hc_coinc_top
    import hc_pkg::*;
#(
    parameter int NROWS    = 4,
    parameter int NCOLS    = 2,
    parameter int CF_DEPTH = 4,
    parameter int GF_DEPTH = 8,
    parameter int OVF_W    = 4,
    parameter int LOST_W   = 8,
    localparam int ROW_W   = (NROWS > 1) ? $clog2(NROWS) : 1,
    localparam int COL_W   = (NCOLS > 1) ? $clog2(NCOLS) : 1,
    localparam int WORD_W  = TID_W + COL_W + ROW_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCOLS*NROWS-1:0]       hit_in,
    input  logic                         trig_in,
    input  logic [LAT_W-1:0]             lat_cfg,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [WORD_W-1:0]            out_word,
    output logic [NCOLS*NROWS*OVF_W-1:0] ovf_cnt,
    output logic [NCOLS*LOST_W-1:0]      lost_cnt
);
    localparam int REC_W = TID_W + ROW_W;

    logic [TID_W-1:0]  tid_q;
    logic [NCOLS-1:0]  col_valid, col_pop;
    logic [REC_W-1:0]  col_rec [NCOLS];
    logic [COL_W-1:0]  gsel;
    logic              gfound, g_push, g_full, g_empty;
    logic [WORD_W-1:0] g_din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tid_q <= '0;
        else if (trig_in) tid_q <= tid_q + TID_W'(1);
    end

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        hc_column #(
            .NROWS (NROWS), .DEPTH (CF_DEPTH), .OVF_W (OVF_W),
            .LOST_W(LOST_W), .TW (TID_W), .LW (LAT_W)
        ) u_col (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit_in[c*NROWS +: NROWS]),
            .trig      (trig_in),
            .tid       (tid_q),
            .lat       (lat_cfg),
            .pop       (col_pop[c]),
            .rec_valid (col_valid[c]),
            .rec       (col_rec[c]),
            .ovf       (ovf_cnt[c*NROWS*OVF_W +: NROWS*OVF_W]),
            .lost      (lost_cnt[c*LOST_W +: LOST_W])
        );
    end

    // lowest non-empty column goes first into the global FIFO
    always_comb begin
        gsel   = '0;
        gfound = 1'b0;
        for (int c = 0; c < NCOLS; c++) begin
            if (col_valid[c] && !gfound) begin
                gsel   = COL_W'(c);
                gfound = 1'b1;
            end
        end
        g_push  = gfound & ~g_full;
        col_pop = '0;
        if (g_push) col_pop[gsel] = 1'b1;
        g_din = {col_rec[gsel][REC_W-1 -: TID_W], gsel, col_rec[gsel][ROW_W-1:0]};
    end

    hc_fifo #(.W(WORD_W), .DEPTH(GF_DEPTH)) u_gfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (g_push),
        .din   (g_din),
        .pop   (out_valid & out_ready),
        .dout  (out_word),
        .empty (g_empty),
        .full  (g_full)
    );
    assign out_valid = ~g_empty;

    // R8: one column served per cycle
    a_r8_single_col: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_pop));
    // R10: a stalled output word stays put
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
    // R6: the trigger number wraps from the top value to zero
    a_r6_tid_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && tid_q == '1) |=> tid_q == '0);
endmodule

// File: tb/hc_coinc_top_test.sv
`timescale 1ns/1ps
module hc_coinc_top_test;
    localparam int NROWS = 4, NCOLS = 2, NPIX = 8, OVF_W = 4, LOST_W = 8;
    localparam int ROW_W = 2, COL_W = 1, WORD_W = 15;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NPIX-1:0]         hit_in = '0;
    logic                    trig_in = 1'b0;
    logic [7:0]              lat_cfg = '0;
    logic                    out_ready = 1'b1;
    logic                    out_valid;
    logic [WORD_W-1:0]       out_word;
    logic [NPIX*OVF_W-1:0]   ovf_cnt;
    logic [NCOLS*LOST_W-1:0] lost_cnt;

    hc_coinc_top uut (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .trig_in(trig_in),
        .lat_cfg(lat_cfg), .out_ready(out_ready), .out_valid(out_valid),
        .out_word(out_word), .ovf_cnt(ovf_cnt), .lost_cnt(lost_cnt)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0, ntrig = 0;
    bit done = 0;
    logic [WORD_W-1:0] got[$];

    always @(negedge clk) if (rst_n && out_valid && out_ready) got.push_back(out_word);

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mkw(int tid, int pix);
        return WORD_W'(((tid % 4096) << (COL_W + ROW_W)) | ((pix / NROWS) << ROW_W) | (pix % NROWS));
    endfunction

    task automatic idle(int n);
        hit_in = '0; trig_in = 1'b0;
        repeat (n) step();
    endtask

    // drive trig this step and return its number
    task automatic fire(output int t);
        trig_in = 1'b1; t = ntrig; ntrig = (ntrig + 1) % 4096;
    endtask

    task automatic run_one(int pix, int lat, int toff);
        int ts, tu;
        got.delete();
        lat_cfg = 8'(lat);
        ts = 1 + lat + toff;
        tu = -1;
        for (int s = 0; s <= 2 + lat; s++) begin
            hit_in  = (s == 0) ? NPIX'(1) << pix : '0;
            trig_in = 1'b0;
            if (s == ts) fire(tu);
            step();
        end
        idle(12);
        if (toff == 0) begin
            chk(got.size() == 1, "R2 word count on time", got.size(), 1);
            if (got.size() == 1)
                chk(got[0] == mkw(tu, pix), "R7 R6 word content", got[0], mkw(tu, pix));
        end else begin
            chk(got.size() == 0, "R2 R11 no word off window", got.size(), 0);
        end
    endtask

    initial begin
        int t1, t2, tr[4];
        logic [WORD_W-1:0] w0;
        repeat (3) step();
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(ovf_cnt == '0, "R1 ovf after reset", ovf_cnt, 0);
        chk(lost_cnt == '0, "R1 lost after reset", lost_cnt, 0);
        rst_n = 1'b1;
        step();

        // R2: sweep pixels, latencies and strobe offsets
        foreach (tr[i]) tr[i] = 0;
        for (int p = 0; p < NPIX; p++)
            for (int li = 0; li < 5; li++)
                for (int o = -1; o <= 1; o++)
                    run_one(p, (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 2 : (li == 3) ? 5 : 255, o);
        chk(ovf_cnt == '0, "R11 no overflow from single hits", ovf_cnt, 0);
        chk(lost_cnt == '0, "R11 no loss from single hits", lost_cnt, 0);

        // R3: latency change after start does not move the test cycle
        got.delete();
        lat_cfg = 8'd3; hit_in = NPIX'(1) << 3; step();
        hit_in = '0; lat_cfg = 8'd10; step();
        idle(2);
        fire(t1); step(); trig_in = 1'b0;
        idle(6);
        fire(t2); step();
        idle(12);
        chk(got.size() == 1, "R3 one word", got.size(), 1);
        if (got.size() == 1) chk(got[0] == mkw(t1, 3), "R3 word from captured latency", got[0], mkw(t1, 3));

        // R4 / R5: pixel 5, latency 10, four hits in a row
        got.delete();
        lat_cfg = 8'd10;
        for (int s = 0; s <= 12; s++) begin
            hit_in = (s < 4) ? NPIX'(1) << 5 : '0;
            trig_in = 1'b0;
            if (s == 11) fire(t1);
            if (s == 12) fire(t2);
            step();
        end
        idle(14);
        chk(got.size() == 2, "R4 both timers read out", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == mkw(t1, 5), "R4 first timer word", got[0], mkw(t1, 5));
            chk(got[1] == mkw(t2, 5), "R4 second timer word", got[1], mkw(t2, 5));
        end
        chk(ovf_cnt[5*OVF_W +: OVF_W] == 4'd2, "R5 overflow count", ovf_cnt[5*OVF_W +: OVF_W], 2);

        // R5: saturation
        lat_cfg = 8'd255;
        for (int s = 0; s < 22; s++) begin hit_in = NPIX'(1) << 5; trig_in = 1'b0; step(); end
        idle(270);
        chk(ovf_cnt[5*OVF_W +: OVF_W] == 4'hF, "R5 overflow saturates", ovf_cnt[5*OVF_W +: OVF_W], 15);
        chk((ovf_cnt & ~(NPIX*OVF_W)'(32'hF << (5*OVF_W))) == '0, "R5 other pixels untouched", ovf_cnt, 0);

        // R8: all pixels hit together
        got.delete();
        lat_cfg = 8'd2;
        hit_in = '1; step();
        hit_in = '0; idle(2);
        fire(t1); step();
        idle(30);
        chk(got.size() == 8, "R8 all words", got.size(), 8);
        for (int i = 0; i < 8; i++)
            if (i < got.size()) chk(got[i] == mkw(t1, i), "R8 priority order", got[i], mkw(t1, i));

        // R9 / R10: stall output, fill FIFOs, force loss
        got.delete();
        out_ready = 1'b0;
        lat_cfg = 8'd0;
        for (int k = 0; k < 4; k++) begin
            hit_in = NPIX'(4'hF); trig_in = 1'b0; step();
            hit_in = '0; fire(tr[k]); step();
            idle(14);
        end
        chk(lost_cnt[LOST_W-1:0] == 8'd4, "R9 lost count column 0", lost_cnt[LOST_W-1:0], 4);
        chk(lost_cnt[2*LOST_W-1:LOST_W] == 8'd0, "R9 lost count column 1", lost_cnt[2*LOST_W-1:LOST_W], 0);
        w0 = out_word;
        chk(out_valid == 1'b1, "R10 valid while stalled", out_valid, 1);
        chk(w0 == mkw(tr[0], 0), "R10 head word", w0, mkw(tr[0], 0));
        idle(3);
        chk(out_word == w0, "R10 word held", out_word, w0);
        out_ready = 1'b1;
        idle(30);
        chk(got.size() == 12, "R9 drained words", got.size(), 12);
        if (got.size() == 12) chk(got[11] == mkw(tr[2], 3), "R9 last kept word", got[11], mkw(tr[2], 3));

        // R9: timers not stalled after loss
        got.delete();
        hit_in = NPIX'(1); step();
        hit_in = '0; fire(t1); step();
        idle(12);
        chk(got.size() == 1 && got[0] == mkw(t1, 0), "R9 timers reusable", got.size(), 1);

        // R6: wrap of the trigger counter
        while (ntrig != 4095) begin fire(t1); step(); end
        trig_in = 1'b0;
        for (int k = 0; k < 2; k++) begin
            got.delete();
            hit_in = NPIX'(1) << 6; trig_in = 1'b0; step();
            hit_in = '0; fire(t1); step();
            idle(12);
            chk(got.size() == 1 && got[0] == mkw(k == 0 ? 4095 : 0, 6), "R6 trigger id wrap",
                (got.size() > 0) ? got[0] : 0, mkw(k == 0 ? 4095 : 0, 6));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule